// File: doc/BRIEF.md
# Phase-Lock Qualifier with Sticky Per-Reference Alarms

This block sits beside a reference-selecting PLL. It takes the raw phase-lock indication that the loop produces for whichever input is currently the main reference. It reports a qualified lock only after that indication has held without a break across two boundaries of a one-second tick. A lock that has reached qualification and then drops leaves a sticky alarm bit against the main reference. A processor clears these bits with a write-one-to-clear mask.

Frequency and activity monitoring happen elsewhere and arrive as per-reference flags. Those flags are checked on every reference all the time. The phase alarm only ever concerns the main reference. The block combines the activity flag, the in-band flag and the alarm bit into a per-reference valid flag, which the selection logic uses.

Top module: `phase_lock_qual`

## Requirements
- R1: After reset, `lock_qual` is 0 and every bit of `phase_alarm` is 0.
- R2: With `raw_lock` continuously high and `main_sel` unchanged, `lock_qual` goes high in the cycle after the second `sec_tick` that is sampled since qualification restarted. A single sampled tick is not enough.
- R3: A cycle with `raw_lock` low clears `lock_qual` on the next cycle and restarts the qualification, so two further ticks are again needed.
- R4: A change of `main_sel` from one cycle to the next clears `lock_qual` on the next cycle and restarts the qualification.
- R5: If `raw_lock` is sampled low while `lock_qual` is high and `main_sel` equals its previous value, bit `main_sel` of `phase_alarm` is set on the next cycle.
- R6: No alarm bit is set when `raw_lock` drops before qualification, or in the same cycle that `main_sel` changes. Bits for other references are never set by a loss.
- R7: When `alarm_clr_we` is high, each `phase_alarm` bit whose `alarm_clr_mask` bit is 1 is cleared on the next cycle. Bits with a 0 in the mask are untouched.
- R8: If a set and a clear hit the same alarm bit in the same cycle, the bit ends up set.
- R9: `ref_valid[k]` is combinationally `ref_active[k] & ref_inband[k] & ~phase_alarm[k]`.
- R10: Alarm bits are sticky: without a clear they stay set regardless of `raw_lock`, `main_sel` or ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| main_sel | input | IDXW | Index of the current main reference |
| raw_lock | input | 1 | Unqualified phase-lock indication from the PLL |
| ref_active | input | NREF | Per-reference activity flag |
| ref_inband | input | NREF | Per-reference in-frequency-band flag |
| alarm_clr_we | input | 1 | Processor clear strobe |
| alarm_clr_mask | input | NREF | Write-one-to-clear mask for alarm bits |
| lock_qual | output | 1 | Qualified phase lock |
| phase_alarm | output | NREF | Sticky phase alarm per reference |
| ref_valid | output | NREF | Active, in band and not alarmed |

## Verification
Qualification is tried in four ways: with one tick only, with two ticks, with a one-cycle dropout between ticks, and with a change of main reference while locked. These separate an off-by-one tick count from a missing restart. Loss of lock is tried after qualification, before qualification, and together with a selection change, which shows whether the alarm is limited to a genuine loss on the main reference. Clears are tried alone, with a mask that misses the set bit, and in the same cycle as a set, which shows the set-over-clear priority. Valid flags are checked against mixed activity and band patterns.

// File: rtl/phase_lock_qual.sv
module phase_lock_qual #(
  parameter int NREF = 4,
  localparam int IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sec_tick,
  input  logic [IDXW-1:0] main_sel,
  input  logic            raw_lock,
  input  logic [NREF-1:0] ref_active,
  input  logic [NREF-1:0] ref_inband,
  input  logic            alarm_clr_we,
  input  logic [NREF-1:0] alarm_clr_mask,
  output logic            lock_qual,
  output logic [NREF-1:0] phase_alarm,
  output logic [NREF-1:0] ref_valid
);

  logic [IDXW-1:0] sel_q;
  logic            first_tick_q;
  logic            sel_moved;
  logic            lost_phase;

  assign sel_moved  = (main_sel != sel_q);
  assign lost_phase = lock_qual & ~raw_lock & ~sel_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= '0;
      first_tick_q <= 1'b0;
      lock_qual    <= 1'b0;
    end else begin
      sel_q <= main_sel;
      if (!raw_lock || sel_moved) begin
        first_tick_q <= 1'b0;
        lock_qual    <= 1'b0;
      end else if (sec_tick) begin
        if (first_tick_q) lock_qual <= 1'b1;
        first_tick_q <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NREF; k++) begin : g_ref
    always_ff @(posedge clk) begin
      if (!rst_n)
        phase_alarm[k] <= 1'b0;
      else if (lost_phase && main_sel == IDXW'(k))
        phase_alarm[k] <= 1'b1;
      else if (alarm_clr_we && alarm_clr_mask[k])
        phase_alarm[k] <= 1'b0;
    end
    assign ref_valid[k] = ref_active[k] & ref_inband[k] & ~phase_alarm[k];
  end

endmodule

module phase_lock_qual_chk #(
  parameter int NREF = 4,
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sec_tick,
  input logic [IDXW-1:0] main_sel,
  input logic            raw_lock,
  input logic            alarm_clr_we,
  input logic [NREF-1:0] alarm_clr_mask,
  input logic            lock_qual,
  input logic [NREF-1:0] phase_alarm
);

  // R2
  lock_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_qual) |-> $past(sec_tick) && $past(raw_lock));

  // R3
  dropout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_lock |=> !lock_qual);

  // R4
  sel_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sel != $past(main_sel)) |=> !lock_qual);

  // R5
  alarm_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_alarm & ~$past(phase_alarm)) != '0) |-> $past(lock_qual) && !$past(raw_lock));

  // R6
  alarm_one_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_alarm & ~$past(phase_alarm)) <= 1);

  // R10
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_clr_we |=> ((phase_alarm & $past(phase_alarm)) == $past(phase_alarm)));

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr_we && !(lock_qual && !raw_lock)) |=> ((phase_alarm & $past(alarm_clr_mask)) == '0));

endmodule

bind phase_lock_qual phase_lock_qual_chk #(.NREF(NREF), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .main_sel(main_sel),
  .raw_lock(raw_lock), .alarm_clr_we(alarm_clr_we), .alarm_clr_mask(alarm_clr_mask),
  .lock_qual(lock_qual), .phase_alarm(phase_alarm)
);

// File: tb/phase_lock_qual_tb.sv
module phase_lock_qual_tb_top;
  localparam int NREF = 4;
  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sec_tick = 1'b0;
  logic [IDXW-1:0] main_sel = '0;
  logic            raw_lock = 1'b0;
  logic [NREF-1:0] ref_active = '1;
  logic [NREF-1:0] ref_inband = '1;
  logic            alarm_clr_we = 1'b0;
  logic [NREF-1:0] alarm_clr_mask = '0;
  logic            lock_qual;
  logic [NREF-1:0] phase_alarm;
  logic [NREF-1:0] ref_valid;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase_lock_qual #(.NREF(NREF)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .main_sel(main_sel),
    .raw_lock(raw_lock), .ref_active(ref_active), .ref_inband(ref_inband),
    .alarm_clr_we(alarm_clr_we), .alarm_clr_mask(alarm_clr_mask),
    .lock_qual(lock_qual), .phase_alarm(phase_alarm), .ref_valid(ref_valid)
  );

  // behavioural model
  bit        m_lock;
  int        m_ticks;
  int        m_psel;
  bit [3:0]  m_alarm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_ticks = 0; m_psel = 0; m_alarm = '0;
    end else begin
      bit moved;
      bit loss;
      moved = (int'(main_sel) != m_psel);
      loss  = m_lock && !raw_lock && !moved;
      if (alarm_clr_we) m_alarm = m_alarm & ~alarm_clr_mask;
      if (loss) m_alarm[main_sel] = 1'b1;
      if (!raw_lock || moved) begin
        m_ticks = 0;
      end else if (sec_tick && m_ticks < 2) begin
        m_ticks = m_ticks + 1;
      end
      m_lock = (m_ticks >= 2);
      m_psel = int'(main_sel);
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model lock", 32'(lock_qual), 32'(m_lock));
      check("R5 model alarm", 32'(phase_alarm), 32'(m_alarm));
      check("R9 model valid", 32'(ref_valid), 32'(ref_active & ref_inband & ~m_alarm));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    sec_tick = 1'b1; step(); sec_tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic probe();
    @(negedge clk);
  endtask

  task automatic qualify();
    idle(2); tick(); idle(3); tick(); idle(1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    probe();
    check("R1 lock", 32'(lock_qual), 0);
    check("R1 alarm", 32'(phase_alarm), 0);

    main_sel = 0; raw_lock = 1'b1;
    step(); tick(); idle(3); probe();
    check("R2 one tick", 32'(lock_qual), 0);
    tick(); probe();
    check("R2 two ticks", 32'(lock_qual), 1);

    raw_lock = 1'b0; step(); raw_lock = 1'b1; probe();
    check("R3 dropout", 32'(lock_qual), 0);
    check("R5 alarm set", 32'(phase_alarm), 4'b0001);
    check("R9 alarmed invalid", 32'(ref_valid), 4'b1110);

    tick(); idle(2);
    raw_lock = 1'b0; step(); raw_lock = 1'b1;
    tick(); idle(2); probe();
    check("R3 restart", 32'(lock_qual), 0);
    check("R6 early loss", 32'(phase_alarm), 4'b0001);
    tick(); probe();
    check("R3 relock", 32'(lock_qual), 1);

    alarm_clr_we = 1'b1; alarm_clr_mask = 4'b0001; step();
    alarm_clr_we = 1'b0; alarm_clr_mask = '0; probe();
    check("R7 clear", 32'(phase_alarm), 0);
    check("R9 all valid", 32'(ref_valid), 4'b1111);

    main_sel = 2; step(); probe();
    check("R4 sel change", 32'(lock_qual), 0);
    check("R6 no alarm on move", 32'(phase_alarm), 0);
    qualify(); probe();
    check("R4 relock", 32'(lock_qual), 1);
    main_sel = 1; raw_lock = 1'b0; step(); probe();
    check("R6 loss with move", 32'(phase_alarm), 0);

    raw_lock = 1'b1; qualify(); probe();
    check("R2 lock sel1", 32'(lock_qual), 1);
    raw_lock = 1'b0; alarm_clr_we = 1'b1; alarm_clr_mask = 4'b0010; step();
    alarm_clr_we = 1'b0; alarm_clr_mask = '0; probe();
    check("R8 set wins", 32'(phase_alarm), 4'b0010);

    alarm_clr_we = 1'b1; alarm_clr_mask = 4'b1101; step();
    alarm_clr_we = 1'b0; alarm_clr_mask = '0;
    raw_lock = 1'b1; main_sel = 3; tick(); idle(4); probe();
    check("R10 sticky", 32'(phase_alarm), 4'b0010);

    ref_active = 4'b1011; ref_inband = 4'b1110; probe();
    check("R9 mix", 32'(ref_valid), 4'b1000);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      raw_lock = (r < 92);
      sec_tick = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 40) == 0) main_sel = IDXW'($urandom_range(0, 3));
      alarm_clr_we = ($urandom_range(0, 15) == 0);
      alarm_clr_mask = NREF'($urandom_range(0, 15));
      ref_active = NREF'($urandom_range(0, 15));
      ref_inband = NREF'($urandom_range(0, 15));
      step();
    end
    sec_tick = 1'b0; alarm_clr_we = 1'b0;
    idle(2); probe();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule